// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block holds the machine-level trap state of one hart and updates it when a synchronous exception is taken or a machine-return instruction retires. When an exception is taken it saves the faulting program counter, records the cause and a trap value chosen by the cause class, and pushes the interrupt-enable and privilege stack. It then raises the hart to machine privilege and sends the fetch unit to the handler address, which comes from the trap-vector register. A machine return pops that stack and sends fetch back to the saved program counter.

Software reaches the trap-vector, exception-PC, cause and status fields through a single-cycle write port, and every owned field is visible on an output. The trap-vector and exception-PC writes are legalized on the way in. A separate handler-address output gives the target that the stored trap-vector and cause currently select, including the vectored offset for causes that are marked as interrupts.

Top module: `mtrap_ctrl`

## Requirements
- R1: After a synchronous active-low reset the privilege output is machine (encoding 3), interrupt-enable, previous-interrupt-enable and previous-privilege (encoding 0, user) are 0, and the exception PC, cause, trap value and trap-vector registers are all zero.
- R2: When trap_req is high at a clock edge, the exception PC takes cur_pc and the cause register takes trap_code zero-extended, with bit XLEN-1 (the interrupt flag) clear.
- R3: When a trap is taken, previous-interrupt-enable takes the old interrupt-enable, interrupt-enable clears, previous-privilege takes the old privilege (user 0, supervisor 1, machine 3) and privilege becomes machine (3).
- R4: When a trap is taken, the trap value becomes zero for the environment-call codes 8, 9 and 11, and becomes trap_info for every other code.
- R5: In the cycle that trap_req is high, redirect_valid is high and redirect_pc is the trap-vector base (bits XLEN-1..2) with bits 1..0 zero. This holds in both modes, because a trap's cause always has its interrupt flag clear.
- R6: handler_pc_o is the trap-vector base with two zero bits appended. In vectored mode (mode field, bits 1..0, equal to 1) with cause bit XLEN-1 set, it is instead that base plus four times cause bits XLEN-2..0.
- R7: A write with wr_sel 0 updates the trap-vector base. It updates the mode bits only when the written mode is 0 (direct) or 1 (vectored); for modes 2 and 3 the previous mode is kept.
- R8: When ret_req is high without trap_req, redirect_pc is the stored exception PC in that cycle. At the edge, interrupt-enable takes previous-interrupt-enable, previous-interrupt-enable sets, privilege takes previous-privilege, and previous-privilege becomes user (0).
- R9: A write with wr_sel 1 stores wr_data into the exception PC with bit 0 cleared, and with bit 1 also cleared when rvc_en is low.
- R10: If trap_req and ret_req are high together, only the trap takes effect. Either strobe blocks any register write in the same cycle.
- R11: A write with wr_sel 2 stores wr_data in the cause register unchanged. A write with wr_sel 3 sets interrupt-enable from bit 3, previous-interrupt-enable from bit 7 and previous-privilege from bits 12..11, except that the reserved previous-privilege value 2 keeps the old field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Take a synchronous exception this cycle |
| trap_code | input | CODE_W | Exception code of the trap |
| trap_info | input | XLEN | Candidate trap value (faulting address or instruction) |
| ret_req | input | 1 | Machine return retires this cycle |
| cur_pc | input | XLEN | Program counter of the trapping instruction |
| rvc_en | input | 1 | Compressed instructions enabled |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 trap-vector, 1 exception PC, 2 cause, 3 status |
| wr_data | input | XLEN | Write data |
| redirect_valid | output | 1 | Fetch must be redirected this cycle |
| redirect_pc | output | XLEN | Redirect target |
| priv_o | output | 2 | Current privilege |
| ie_o | output | 1 | Interrupt-enable |
| pie_o | output | 1 | Previous interrupt-enable |
| pp_o | output | 2 | Previous privilege |
| epc_o | output | XLEN | Exception PC |
| cause_o | output | XLEN | Cause register |
| tval_o | output | XLEN | Trap value |
| tvec_o | output | XLEN | Trap-vector register |
| handler_pc_o | output | XLEN | Handler address selected by the stored trap-vector and cause |

## Verification
The vectored offset is the hardest case to reach, because a trap always writes a cause with the interrupt flag clear, so no trap can ever produce an offset target. The stimulus reaches it by writing the cause register directly with the flag set while the trap-vector is in vectored mode. It then switches the mode back to direct to show that the offset disappears. Returns to user and supervisor privilege are set up by writing previous-privilege before the return. A trap is then taken from that lower level, which shows that the saved privilege field follows the actual level.

// File: rtl/mtrap_pkg.sv
// Package mtrap_pkg
// Shared encodings for the trap controller: privilege levels, write
// targets and the trap-vector modes. Assumes a two-bit privilege field.
package mtrap_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [1:0] SEL_TVEC   = 2'd0;
    localparam logic [1:0] SEL_EPC    = 2'd1;
    localparam logic [1:0] SEL_CAUSE  = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    localparam logic [1:0] MODE_DIRECT = 2'd0;
    localparam logic [1:0] MODE_VECTOR = 2'd1;

    // Status field positions inside a status write word
    localparam int ST_IE_BIT  = 3;
    localparam int ST_PIE_BIT = 7;
    localparam int ST_PP_LO   = 11;
endpackage

// File: rtl/mtrap_tvec.sv
// Module mtrap_tvec
// Holds the trap-vector register, legalizes its mode on write and
// computes two targets: the trap entry target (interrupt flag clear)
// and the handler for the stored cause. Assumes XLEN >= 4.
module mtrap_tvec
    import mtrap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] tvec,
    output logic [XLEN-1:0] entry_pc,
    output logic [XLEN-1:0] handler_pc
);
    logic [XLEN-1:0] tvec_q;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic [1:0]      wmode;

    assign wmode = wr_data[1:0];

    // Register update: base always taken, mode only when legal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tvec_q <= '0;
        end else if (wr_en) begin
            tvec_q[XLEN-1:2] <= wr_data[XLEN-1:2];
            if (wmode == MODE_DIRECT || wmode == MODE_VECTOR)
                tvec_q[1:0] <= wmode;
        end
    end

    // Target computation from base, mode and cause
    always_comb begin
        base       = {tvec_q[XLEN-1:2], 2'b00};
        offset     = {cause[XLEN-3:0], 2'b00};
        entry_pc   = base;
        handler_pc = base;
        if (tvec_q[1:0] == MODE_VECTOR && cause[XLEN-1])
            handler_pc = base + offset;
    end

    assign tvec = tvec_q;
endmodule

// File: rtl/mtrap_tval_sel.sv
// Module mtrap_tval_sel
// Chooses the trap value by cause class: environment calls give zero,
// all other exception codes pass the supplied value. Assumes CODE_W >= 4.
module mtrap_tval_sel #(
    parameter int XLEN   = 64,
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   info,
    output logic [XLEN-1:0]   tval
);
    localparam logic [CODE_W-1:0] ECALL_U = CODE_W'(8);
    localparam logic [CODE_W-1:0] ECALL_S = CODE_W'(9);
    localparam logic [CODE_W-1:0] ECALL_M = CODE_W'(11);

    logic is_ecall;

    // Cause class decode
    always_comb begin
        is_ecall = (code == ECALL_U) || (code == ECALL_S) || (code == ECALL_M);
        tval     = is_ecall ? '0 : info;
    end
endmodule

// File: rtl/mtrap_status.sv
// Module mtrap_status
// Owns the privilege level and the interrupt-enable stack fields.
// Trap pushes, return pops, software write loads; the caller guarantees
// at most one of take/ret/wr is high in a cycle.
module mtrap_status
    import mtrap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            ret,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [1:0]      priv,
    output logic            ie,
    output logic            pie,
    output logic [1:0]      pp
);
    logic [1:0] wpp;

    assign wpp = wr_data[ST_PP_LO+1:ST_PP_LO];

    // Privilege and enable stack update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv <= PRIV_M;
            ie   <= 1'b0;
            pie  <= 1'b0;
            pp   <= PRIV_U;
        end else if (take) begin
            pie  <= ie;
            ie   <= 1'b0;
            pp   <= priv;
            priv <= PRIV_M;
        end else if (ret) begin
            ie   <= pie;
            pie  <= 1'b1;
            priv <= pp;
            pp   <= PRIV_U;
        end else if (wr_en) begin
            ie  <= wr_data[ST_IE_BIT];
            pie <= wr_data[ST_PIE_BIT];
            if (wpp != 2'd2)
                pp <= wpp;
        end
    end
endmodule

// File: rtl/mtrap_ctrl.sv
// Module mtrap_ctrl
// Top of the trap controller. Holds exception PC, cause and trap value,
// routes writes to the owned registers, and drives the fetch redirect.
// Trap has priority over return; either strobe blocks software writes.
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_info,
    input  logic              ret_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              rvc_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [1:0]        priv_o,
    output logic              ie_o,
    output logic              pie_o,
    output logic [1:0]        pp_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   tval_o,
    output logic [XLEN-1:0]   tvec_o,
    output logic [XLEN-1:0]   handler_pc_o
);
    localparam int PAD_W = XLEN - CODE_W;

    logic            take, do_ret, sw_wr;
    logic            wr_tvec, wr_epc, wr_cause, wr_stat;
    logic [XLEN-1:0] epc_q, cause_q, tval_q;
    logic [XLEN-1:0] tval_new, entry_pc, epc_mask;

    // Strobe arbitration
    always_comb begin
        take     = trap_req;
        do_ret   = ret_req && !trap_req;
        sw_wr    = wr_en && !trap_req && !ret_req;
        wr_tvec  = sw_wr && (wr_sel == SEL_TVEC);
        wr_epc   = sw_wr && (wr_sel == SEL_EPC);
        wr_cause = sw_wr && (wr_sel == SEL_CAUSE);
        wr_stat  = sw_wr && (wr_sel == SEL_STATUS);
        epc_mask = {{(XLEN-2){1'b1}}, rvc_en, 1'b0};
    end

    mtrap_tvec #(.XLEN(XLEN)) tvec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_tvec),
        .wr_data    (wr_data),
        .cause      (cause_q),
        .tvec       (tvec_o),
        .entry_pc   (entry_pc),
        .handler_pc (handler_pc_o)
    );

    mtrap_tval_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) tval_i (
        .code (trap_code),
        .info (trap_info),
        .tval (tval_new)
    );

    mtrap_status #(.XLEN(XLEN)) status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .ret     (do_ret),
        .wr_en   (wr_stat),
        .wr_data (wr_data),
        .priv    (priv_o),
        .ie      (ie_o),
        .pie     (pie_o),
        .pp      (pp_o)
    );

    // Exception PC, cause and trap value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
        end else if (take) begin
            epc_q   <= cur_pc;
            cause_q <= {{PAD_W{1'b0}}, trap_code};
            tval_q  <= tval_new;
        end else begin
            if (wr_epc)
                epc_q <= wr_data & epc_mask;
            if (wr_cause)
                cause_q <= wr_data;
        end
    end

    // Fetch redirect selection
    always_comb begin
        redirect_valid = take || do_ret;
        redirect_pc    = '0;
        if (take)
            redirect_pc = entry_pc;
        else if (do_ret)
            redirect_pc = epc_q;
    end

    assign epc_o   = epc_q;
    assign cause_o = cause_q;
    assign tval_o  = tval_q;
endmodule

// File: rtl/mtrap_ctrl_chk.sv
// Module mtrap_ctrl_chk
// Property checker for mtrap_ctrl, attached through bind below.
module mtrap_ctrl_chk #(
    parameter int XLEN   = 64,
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_req,
    input logic              ret_req,
    input logic [XLEN-1:0]   cur_pc,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [1:0]        priv_o,
    input logic              ie_o,
    input logic              pie_o,
    input logic [1:0]        pp_o,
    input logic [XLEN-1:0]   epc_o,
    input logic [XLEN-1:0]   cause_o,
    input logic [XLEN-1:0]   tvec_o
);
    a_r3_trap_to_machine: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (priv_o == 2'd3) && !ie_o);

    a_r3_stack_push: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (pie_o == $past(ie_o)) && (pp_o == $past(priv_o)));

    a_r2_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (epc_o == $past(cur_pc)) && !cause_o[XLEN-1]);

    a_r8_ret_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req) |=> (priv_o == $past(pp_o)) && (pp_o == 2'd0)
                                   && pie_o && (ie_o == $past(pie_o)));

    a_r9_epc_even: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && !trap_req && !ret_req) |=> !epc_o[0]);

    a_r7_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !tvec_o[1]);

    a_r10_no_write_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req && wr_en && wr_sel == 2'd2) |=> $stable(cause_o));
endmodule

bind mtrap_ctrl mtrap_ctrl_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_req (trap_req),
    .ret_req  (ret_req),
    .cur_pc   (cur_pc),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .priv_o   (priv_o),
    .ie_o     (ie_o),
    .pie_o    (pie_o),
    .pp_o     (pp_o),
    .epc_o    (epc_o),
    .cause_o  (cause_o),
    .tvec_o   (tvec_o)
);

// File: tb/mtrap_ctrl_tb_top.sv
// Scoreboard bench for mtrap_ctrl: the driver computes expected state
// from the requirements and queues it; the monitor pops and compares.
module mtrap_ctrl_tb_top;
    localparam int XLEN   = 64;
    localparam int CODE_W = 6;

    typedef struct {
        string            tag;
        logic [1:0]       priv;
        logic             ie;
        logic             pie;
        logic [1:0]       pp;
        logic [XLEN-1:0]  epc;
        logic [XLEN-1:0]  cause;
        logic [XLEN-1:0]  tval;
        logic [XLEN-1:0]  tvec;
        logic [XLEN-1:0]  handler;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_req = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [XLEN-1:0]   trap_info = '0;
    logic              ret_req = 1'b0;
    logic [XLEN-1:0]   cur_pc = '0;
    logic              rvc_en = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [XLEN-1:0]   wr_data = '0;
    logic              redirect_valid;
    logic [XLEN-1:0]   redirect_pc;
    logic [1:0]        priv_o, pp_o;
    logic              ie_o, pie_o;
    logic [XLEN-1:0]   epc_o, cause_o, tval_o, tvec_o, handler_pc_o;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];

    // Bench model state
    logic [1:0]      m_priv = 2'd3, m_pp = 2'd0;
    logic            m_ie = 1'b0, m_pie = 1'b0;
    logic [XLEN-1:0] m_epc = '0, m_cause = '0, m_tval = '0, m_tvec = '0;

    always #2 clk = ~clk;

    mtrap_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_code(trap_code),
        .trap_info(trap_info), .ret_req(ret_req), .cur_pc(cur_pc), .rvc_en(rvc_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .priv_o(priv_o), .ie_o(ie_o), .pie_o(pie_o), .pp_o(pp_o),
        .epc_o(epc_o), .cause_o(cause_o), .tval_o(tval_o), .tvec_o(tvec_o),
        .handler_pc_o(handler_pc_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_handler(input logic [XLEN-1:0] tv,
                                                    input logic [XLEN-1:0] ca);
        logic [XLEN-1:0] b;
        b = {tv[XLEN-1:2], 2'b00};
        if (tv[1:0] == 2'd1 && ca[XLEN-1])
            return b + {ca[XLEN-3:0], 2'b00};
        return b;
    endfunction

    function automatic exp_t snap(input string tag);
        exp_t e;
        e.tag = tag; e.priv = m_priv; e.ie = m_ie; e.pie = m_pie; e.pp = m_pp;
        e.epc = m_epc; e.cause = m_cause; e.tval = m_tval; e.tvec = m_tvec;
        e.handler = exp_handler(m_tvec, m_cause);
        return e;
    endfunction

    // Driver: apply one cycle of stimulus, check redirect, queue expected state
    task automatic step(input string tag, input logic t, input logic [CODE_W-1:0] code,
                        input logic [XLEN-1:0] info, input logic r,
                        input logic [XLEN-1:0] pc, input logic rvc, input logic we,
                        input logic [1:0] sel, input logic [XLEN-1:0] wd);
        logic [1:0] wpp;
        @(negedge clk);
        trap_req = t; trap_code = code; trap_info = info; ret_req = r;
        cur_pc = pc; rvc_en = rvc; wr_en = we; wr_sel = sel; wr_data = wd;
        #1;
        check(tag, "redirect_valid", XLEN'(redirect_valid), XLEN'(t | r));
        if (t)      check(tag, "redirect_pc", redirect_pc, {m_tvec[XLEN-1:2], 2'b00});
        else if (r) check(tag, "redirect_pc", redirect_pc, m_epc);
        @(posedge clk);
        if (t) begin
            m_epc = pc; m_cause = XLEN'(code);
            m_tval = (code == 8 || code == 9 || code == 11) ? '0 : info;
            m_pie = m_ie; m_ie = 1'b0; m_pp = m_priv; m_priv = 2'd3;
        end else if (r) begin
            m_ie = m_pie; m_pie = 1'b1; m_priv = m_pp; m_pp = 2'd0;
        end else if (we) begin
            case (sel)
                2'd0: begin
                    m_tvec[XLEN-1:2] = wd[XLEN-1:2];
                    if (wd[1:0] < 2) m_tvec[1:0] = wd[1:0];
                end
                2'd1: m_epc = wd & {{(XLEN-2){1'b1}}, rvc, 1'b0};
                2'd2: m_cause = wd;
                default: begin
                    m_ie = wd[3]; m_pie = wd[7]; wpp = wd[12:11];
                    if (wpp != 2'd2) m_pp = wpp;
                end
            endcase
        end
        sb_q.push_back(snap(tag));
    endtask

    task automatic idle();
        @(negedge clk);
        trap_req = 0; ret_req = 0; wr_en = 0;
    endtask

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "priv", XLEN'(priv_o), XLEN'(e.priv));
            check(e.tag, "ie", XLEN'(ie_o), XLEN'(e.ie));
            check(e.tag, "pie", XLEN'(pie_o), XLEN'(e.pie));
            check(e.tag, "pp", XLEN'(pp_o), XLEN'(e.pp));
            check(e.tag, "epc", epc_o, e.epc);
            check(e.tag, "cause", cause_o, e.cause);
            check(e.tag, "tval", tval_o, e.tval);
            check(e.tag, "tvec", tvec_o, e.tvec);
            check(e.tag, "handler", handler_pc_o, e.handler);
        end
    end

    initial begin : watchdog
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        sb_q.push_back(snap("R1"));          // reset state
        // R11: status write ie=1, pie=0, pp=U
        step("R11", 0, 0, 0, 0, 0, 1, 1, 2'd3, 64'h8);
        // R7: vectored trap-vector at 0x1000
        step("R7", 0, 0, 0, 0, 0, 1, 1, 2'd0, 64'h1001);
        // R2 R3 R4 R5: illegal instruction from machine, value kept
        step("R2", 1, 6'd2, 64'hDEAD, 0, 64'h8000_0004, 1, 0, 0, 0);
        // R8: return to machine, ie restored from pie
        step("R8", 0, 0, 0, 1, 0, 1, 0, 0, 0);
        // R7: illegal mode 3 keeps vectored, base moves
        step("R7", 0, 0, 0, 0, 0, 1, 1, 2'd0, 64'h2003);
        // R6: cause marked interrupt, code 7 -> base + 28
        step("R6", 0, 0, 0, 0, 0, 1, 1, 2'd2, 64'h8000_0000_0000_0007);
        // R11: reserved pp value 2 keeps old pp
        step("R11", 0, 0, 0, 0, 0, 1, 1, 2'd3, 64'h1088);
        // R8: set pp=U, then return to user
        step("R8", 0, 0, 0, 0, 0, 1, 1, 2'd3, 64'h0080);
        step("R8", 0, 0, 0, 1, 0, 1, 0, 0, 0);
        // R4 R3: user environment call, value forced to zero
        step("R4", 1, 6'd8, 64'h55, 0, 64'h400, 1, 0, 0, 0);
        // R9: exception PC alignment with and without compressed
        step("R9", 0, 0, 0, 0, 0, 1, 1, 2'd1, 64'h1237);
        step("R9", 0, 0, 0, 0, 0, 0, 1, 2'd1, 64'h1237);
        // R3: return to supervisor, then supervisor call
        step("R3", 0, 0, 0, 0, 0, 1, 1, 2'd3, 64'h0888);
        step("R3", 0, 0, 0, 1, 0, 1, 0, 0, 0);
        step("R4", 1, 6'd9, 64'h77, 0, 64'h500, 1, 0, 0, 0);
        // R10: trap and return together, plus a blocked write
        step("R10", 1, 6'd5, 64'hBEEF, 1, 64'h600, 1, 1, 2'd0, 64'h3000);
        step("R10", 0, 0, 0, 1, 0, 1, 1, 2'd2, 64'h1234);
        // R4: machine call gives zero; page fault passes value
        step("R4", 1, 6'd11, 64'h99, 0, 64'h700, 1, 0, 0, 0);
        step("R4", 1, 6'd13, 64'hABC, 0, 64'h704, 1, 0, 0, 0);
        // R6: direct mode ignores the interrupt flag
        step("R6", 0, 0, 0, 0, 0, 1, 1, 2'd2, 64'h8000_0000_0000_0003);
        step("R6", 0, 0, 0, 0, 0, 1, 1, 2'd0, 64'h4000);
        step("R5", 1, 6'd1, 64'h10, 0, 64'h800, 1, 0, 0, 0);
        idle();
        idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule